// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A one-cycle start pulse captures a starting column, a three-bit burst-length code, a wrap-order bit and the access direction. From the next cycle on, the block presents one column address per clock with a valid flag. It raises a last flag on the final beat of a fixed-length burst.

Bursts of 1, 2, 4 and 8 beats wrap inside an aligned group of columns, in either sequential or interleaved order. The full-page setting walks the whole 512-column page and wraps around it. It runs until a stop input ends it. A separate option makes writes single-beat while reads keep the programmed length. A command sequencer uses the block to place the column address on the address bus alongside each read or write beat.

Top module: `burst_col_gen`

## Requirements
- R1: After a synchronous active-low reset, `col_valid` and `col_last` are both 0.
- R2: In the cycle after a clock edge that samples `start` high, `col_valid` is 1 and `col_out` equals the `start_col` sampled at that edge.
- R3: `len_code` 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. `col_last` is 1 on the final beat only, and `col_valid` is 0 in the cycle after it unless a new start was sampled.
- R4: With `wrap_il` = 0 (sequential), beat k shows the low log2(N) bits of the start column plus k, modulo N. The upper column bits stay those of the start column.
- R5: With `wrap_il` = 1 (interleaved), beat k shows the low log2(N) bits of the start column XOR k. The upper column bits stay those of the start column.
- R6: `len_code` 111 selects full page: beats continue without end, wrapping across all 512 columns in the selected order, and `col_last` stays 0.
- R7: `stop` sampled high during a burst, without `start`, ends it: `col_valid` is 0 in the next cycle. `stop` while idle has no effect.
- R8: `start` sampled during a burst restarts it from the new start column with the newly sampled settings. `start` takes priority over `stop`.
- R9: When `single_wr` = 1 and `is_write` = 1 at start, the burst is one beat whatever `len_code` says. Reads, or writes with `single_wr` = 0, use the programmed length.
- R10: The unused length codes 100, 101 and 110 behave as a burst of one beat.
- R11: `len_code`, `wrap_il`, `is_write`, `single_wr` and `start_col` are sampled only with `start`. Changing them during a burst does not alter its addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin (or restart) a burst |
| stop | input | 1 | Terminate the running burst |
| start_col | input | 9 | Starting column of the burst |
| len_code | input | 3 | Burst-length code (see R3, R6, R10) |
| wrap_il | input | 1 | 0 sequential, 1 interleaved order |
| is_write | input | 1 | The burst is a write access |
| single_wr | input | 1 | Force writes to one beat |
| col_out | output | 9 | Column address of the current beat |
| col_valid | output | 1 | `col_out` holds a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The hardest case to reach is the wrap of a full-page burst across the page boundary. Only a burst left running for hundreds of beats gets there. The bench starts a sequential full-page burst two columns below the top of the page. It then follows it for more than 512 beats, so both the 511-to-0 step and a return to the start column are observed before `stop` ends it. Restart and mid-burst setting changes are reached by raising `start`, or changing the settings, after a known number of beats of a running burst.

// File: rtl/burst_col_pkg.sv
// Package: shared length codes for the burst column generator.
// Assumes: length code is three bits wide as held in the mode register.
package burst_col_pkg;
    localparam int LEN_CODE_W = 3;
    typedef logic [LEN_CODE_W-1:0] len_code_t;

    localparam len_code_t LEN_ONE   = 3'b000;
    localparam len_code_t LEN_TWO   = 3'b001;
    localparam len_code_t LEN_FOUR  = 3'b010;
    localparam len_code_t LEN_EIGHT = 3'b011;
    localparam len_code_t LEN_PAGE  = 3'b111;
endpackage

// File: rtl/bcg_len_decode.sv
// Module: turns the length code and write options into a wrap mask.
// The mask has ones in the column bits that move during the burst.
// Its value is also the index of the final beat.
// Assumes: unused codes and single-beat writes produce a zero mask.
module bcg_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  len_code_t        len_code,
    input  logic             is_write,
    input  logic             single_wr,
    output logic [COL_W-1:0] wrap_mask,
    output logic             page_mode
);
    localparam logic [COL_W-1:0] MASK2 = COL_W'(1);
    localparam logic [COL_W-1:0] MASK4 = COL_W'(3);
    localparam logic [COL_W-1:0] MASK8 = COL_W'(7);

    // Select mask and page flag from the code and the write override.
    always_comb begin
        wrap_mask = '0;
        page_mode = 1'b0;
        if (!(is_write && single_wr)) begin
            case (len_code)
                LEN_TWO:   wrap_mask = MASK2;
                LEN_FOUR:  wrap_mask = MASK4;
                LEN_EIGHT: wrap_mask = MASK8;
                LEN_PAGE: begin
                    wrap_mask = '1;
                    page_mode = 1'b1;
                end
                default:   wrap_mask = '0;
            endcase
        end
    end
endmodule

// File: rtl/bcg_seq_state.sv
// Module: burst state registers and beat counter.
// Captures the settings on start, then counts beats until the final
// beat, a stop, or a restart.
// Assumes: start has priority over stop; full page never ends by itself.
module bcg_seq_state #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] base_in,
    input  logic [COL_W-1:0] mask_in,
    input  logic             page_in,
    input  logic             il_in,
    output logic             active,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] mask_q,
    output logic [COL_W-1:0] beat_q,
    output logic             il_q,
    output logic             last
);
    logic page_q;

    // Final beat: counter reached the mask in a fixed-length burst.
    always_comb begin
        last = active && !page_q && (beat_q == mask_q);
    end

    // Activity flag and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            beat_q <= '0;
        end else if (active) begin
            if (stop || last) begin
                active <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Settings captured only when a burst starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            page_q <= 1'b0;
            il_q   <= 1'b0;
        end else if (start) begin
            base_q <= base_in;
            mask_q <= mask_in;
            page_q <= page_in;
            il_q   <= il_in;
        end
    end
endmodule

// File: rtl/bcg_addr_mix.sv
// Module: forms the column from base, beat count and wrap mask.
// Masked bits take base+count (sequential) or base^count
// (interleaved). Unmasked bits keep the base.
// Assumes: beat count stays within the mask for fixed bursts.
module bcg_addr_mix #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             il,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;

    // Sequential candidate; carries into unmasked bits are dropped.
    always_comb begin
        seq_sum = base + beat;
    end

    // Per-bit selection between moving and fixed column bits.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = mask[i] ? (il ? (base[i] ^ beat[i]) : seq_sum[i])
                                : base[i];
    end
endmodule

// File: rtl/burst_col_gen.sv
// Module: top of the burst column generator.
// One address per clock from the cycle after start, with valid and
// last flags.
// Assumes: start and stop are single-cycle pulses from a sequencer.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             wrap_il,
    input  logic             is_write,
    input  logic             single_wr,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             st_active;
    logic [COL_W-1:0] st_base;
    logic [COL_W-1:0] st_mask;
    logic [COL_W-1:0] st_beat;
    logic             st_il;
    logic             st_last;
    logic [COL_W-1:0] mix_col;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code (len_code),
        .is_write (is_write),
        .single_wr(single_wr),
        .wrap_mask(dec_mask),
        .page_mode(dec_page)
    );

    bcg_seq_state #(.COL_W(COL_W)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stop   (stop),
        .base_in(start_col),
        .mask_in(dec_mask),
        .page_in(dec_page),
        .il_in  (wrap_il),
        .active (st_active),
        .base_q (st_base),
        .mask_q (st_mask),
        .beat_q (st_beat),
        .il_q   (st_il),
        .last   (st_last)
    );

    bcg_addr_mix #(.COL_W(COL_W)) u_mix (
        .base(st_base),
        .beat(st_beat),
        .mask(st_mask),
        .il  (st_il),
        .col (mix_col)
    );

    // Drive outputs from the state and the address mixer.
    always_comb begin
        col_out   = mix_col;
        col_valid = st_active;
        col_last  = st_last;
    end
endmodule

// File: rtl/burst_col_gen_chk.sv
// Checker: port-level timing properties of the burst column generator.
module burst_col_gen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             col_last
);
    a_r3_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    a_r2_start_shows_col: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_out == $past(start_col)));

    a_r3_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start) |=> !col_valid);

    a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && stop && !start) |=> !col_valid);

    a_r7_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_valid && !start) |=> !col_valid);

    a_r6_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !stop && !start) |=> col_valid);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stop     (stop),
    .start_col(start_col),
    .col_out  (col_out),
    .col_valid(col_valid),
    .col_last (col_last)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // Vector: {start_col[8:0], len_code[2:0], wrap_il, is_write, single_wr}
    localparam logic [14:0] VEC [NVEC] = '{
        {9'd37,  3'b000, 1'b0, 1'b0, 1'b0},  // R3 one beat
        {9'd37,  3'b001, 1'b0, 1'b0, 1'b0},  // R3 R4 two
        {9'd38,  3'b010, 1'b0, 1'b0, 1'b0},  // R4 four
        {9'd301, 3'b011, 1'b0, 1'b0, 1'b0},  // R4 eight
        {9'd301, 3'b011, 1'b1, 1'b0, 1'b0},  // R5 eight
        {9'd150, 3'b010, 1'b1, 1'b0, 1'b0},  // R5 four
        {9'd511, 3'b001, 1'b1, 1'b0, 1'b0},  // R5 two
        {9'd100, 3'b011, 1'b0, 1'b1, 1'b1},  // R9 single write
        {9'd100, 3'b011, 1'b0, 1'b0, 1'b1},  // R9 read keeps length
        {9'd100, 3'b010, 1'b1, 1'b1, 1'b0},  // R9 write, option off
        {9'd77,  3'b101, 1'b0, 1'b0, 1'b0},  // R10 unused code
        {9'd77,  3'b110, 1'b1, 1'b0, 1'b0}   // R10 unused code
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       wrap_il = 1'b0;
    logic       is_write = 1'b0;
    logic       single_wr = 1'b0;
    logic [8:0] col_out;
    logic       col_valid;
    logic       col_last;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .start_col(start_col), .len_code(len_code), .wrap_il(wrap_il),
        .is_write(is_write), .single_wr(single_wr),
        .col_out(col_out), .col_valid(col_valid), .col_last(col_last)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [2:0] lc, input logic wr,
                                    input logic sw);
        if (wr && sw) return 1;
        case (lc)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            3'b111:  return 512;
            default: return 1;
        endcase
    endfunction

    function automatic int col_of(input int base, input int k, input int n,
                                  input logic il);
        int m = n - 1;
        int lo = il ? ((base ^ k) & m) : ((base + k) & m);
        return (base & ~m & 511) | lo;
    endfunction

    task automatic launch(input logic [8:0] c, input logic [2:0] lc,
                          input logic il, input logic wr, input logic sw);
        start_col = c; len_code = lc; wrap_il = il;
        is_write = wr; single_wr = sw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_fixed(input string req, input logic [8:0] c,
                             input logic [2:0] lc, input logic il,
                             input logic wr, input logic sw);
        int n = beats_of(lc, wr, sw);
        launch(c, lc, il, wr, sw);
        for (int k = 0; k < n; k++) begin
            check(req, int'(col_valid), 1);
            check(req, int'(col_out), col_of(int'(c), k, n, il));
            check(req, int'(col_last), (k == n - 1) ? 1 : 0);
            @(negedge clk);
        end
        check(req, int'(col_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", int'(col_valid), 0);
        check("R1 last", int'(col_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", int'(col_valid), 0);

        // Table of vectors (R2 R3 R4 R5 R9 R10)
        for (int v = 0; v < NVEC; v++) begin
            run_fixed("R2-vector", VEC[v][14:6], VEC[v][5:3], VEC[v][2],
                      VEC[v][1], VEC[v][0]);
        end

        // R7 stop while idle has no effect
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R7 idle stop", int'(col_valid), 0);

        // R6 full page sequential across the page top, then R7 stop
        launch(9'd510, 3'b111, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 516; k++) begin
            check("R6 valid", int'(col_valid), 1);
            check("R6 col", int'(col_out), (510 + k) % 512);
            check("R6 last", int'(col_last), 0);
            if (k == 515) stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        check("R7 stop ends", int'(col_valid), 0);

        // R6 full page interleaved, stopped after 20 beats
        launch(9'd5, 3'b111, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 20; k++) begin
            check("R6 il col", int'(col_out), 5 ^ k);
            if (k == 19) stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        check("R7 il stop", int'(col_valid), 0);

        // R8 restart during a burst, start wins over stop
        launch(9'd16, 3'b011, 1'b0, 1'b0, 1'b0);
        check("R8 first", int'(col_out), 16);
        @(negedge clk);
        check("R8 second", int'(col_out), 17);
        stop = 1'b1;
        launch(9'd42, 3'b010, 1'b1, 1'b0, 1'b0);
        stop = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R8 valid", int'(col_valid), 1);
            check("R8 col", int'(col_out), col_of(42, k, 4, 1'b1));
            check("R8 last", int'(col_last), (k == 3) ? 1 : 0);
            @(negedge clk);
        end
        check("R8 end", int'(col_valid), 0);

        // R11 settings changed mid-burst are ignored
        launch(9'd10, 3'b001, 1'b0, 1'b0, 1'b0);
        start_col = 9'd200; len_code = 3'b011; wrap_il = 1'b1;
        check("R11 beat0", int'(col_out), 10);
        check("R11 last0", int'(col_last), 0);
        @(negedge clk);
        check("R11 beat1", int'(col_out), 11);
        check("R11 last1", int'(col_last), 1);
        @(negedge clk);
        check("R11 ended", int'(col_valid), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule